// File: doc/BRIEF.md
# Byte-Programmed Timer Output Compare Channel

This block is one compare channel of a timer. It watches a 16-bit prescaled counter, which it receives together with a strobe that marks each counter advance. It compares the counter with a 16-bit compare register. When the two are equal on an advance strobe, the channel does three things. It sets a compare flag. It may raise an interrupt. It copies a programmed level bit into an output level register that drives a pin through a direction gate.

Software reaches the channel over an 8-bit bus. The bus has four byte locations:
- a control byte at 0x12,
- a status byte at 0x13,
- the compare high byte at 0x16,
- the compare low byte at 0x17.

A two-byte update of the compare value should begin with the high byte. Writing the high byte suspends matching until the low byte arrives, so a half-written value can never cause a false event. The flag is cleared with a handshake: software reads the status byte while the flag is set, then writes the compare low byte.

Top module: `ocmp_unit`

## Requirements
- R1: After synchronous reset the following are all 0: the control byte (read at 0x12), the status byte (read at 0x13), the interrupt, the pin value and the pin enable.
- R2: The compare high byte reads back at 0x16 and the low byte at 0x17. Writing either byte leaves the other byte unchanged.
- R3: The compare register is changed only by bus writes. It is unchanged by a match and by reset.
- R4: After a write to 0x16, matches are suppressed until 0x17 is written. From the next advance strobe onward, the new full value matches normally.
- R5: A write to 0x17 alone does not suppress matching.
- R6: The flag (status bit 0) is set one clock after a cycle in which the advance strobe is high and the counter equals the compare register. The compare uses the register value held before any write in that same cycle. An equal counter without the strobe, or a strobe with an unequal counter, has no effect.
- R7: On every match, control bit 0 (level) is copied to the output level register, whether or not the flag is already set.
- R8: The interrupt output is high exactly when the flag is set and control bit 1 (interrupt enable) is set.
- R9: The pin enable is high only when control bit 2 (direction) is set and at least one match has occurred since reset. The pin value is the output level register.
- R10: A read of 0x13 while the flag is set, followed later by a write to 0x17, clears the flag. A write to 0x17 without that prior read leaves the flag set.
- R11: If a match falls in the same cycle as the clearing write to 0x17, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data for bus_addr |
| cnt_value | input | 16 | Prescaled counter value |
| cnt_tick | input | 1 | Counter advance strobe |
| irq | output | 1 | Compare interrupt request |
| pin_val | output | 1 | Output level register |
| pin_oe | output | 1 | Pin drive enable |

## Verification
The flag-clearing write to the low byte and a compare match can land in the same clock cycle. In that cycle one path tries to clear the flag and the other tries to set it. The bench provokes this by first arming the clear with a status read. It then issues the low-byte write in the same cycle as an advance strobe whose counter equals the stored compare value. The check passes only if the interrupt and the status bit both remain set afterwards. Separate cases confirm that the same write clears the flag when no strobe accompanies it.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

    localparam int unsigned BUS_W  = 8;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned CMP_W  = 2 * BUS_W;

    localparam logic [ADDR_W-1:0] A_CTL = 8'h12;
    localparam logic [ADDR_W-1:0] A_STS = 8'h13;
    localparam logic [ADDR_W-1:0] A_HI  = 8'h16;
    localparam logic [ADDR_W-1:0] A_LO  = 8'h17;

    typedef struct packed {
        logic dir;   // bit 2: pin drive direction
        logic ien;   // bit 1: interrupt enable
        logic lvl;   // bit 0: level copied on match
    } ctl_t;

    localparam int unsigned CTL_W = $bits(ctl_t);

    typedef struct packed {
        logic hit_flag;
        logic level;
        logic seen;
    } cmp_state_t;

    function automatic logic addr_is(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] b);
        return a == b;
    endfunction

endpackage

// File: rtl/ocmp_regfile.sv
module ocmp_regfile
    import ocmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic              we,
    input  logic              re,
    output ctl_t              ctl_o,
    output logic [CMP_W-1:0]  cmp_o,
    output logic              inhibit_o,
    output logic              lo_wr_o,
    output logic              sts_rd_o
);
    logic [BUS_W-1:0] hi_q, lo_q;
    ctl_t             ctl_q;
    logic             inh_q;
    logic             hi_wr, ctl_wr;

    assign hi_wr    = we && addr_is(addr, A_HI);
    assign lo_wr_o  = we && addr_is(addr, A_LO);
    assign ctl_wr   = we && addr_is(addr, A_CTL);
    assign sts_rd_o = re && addr_is(addr, A_STS);

    // compare bytes carry no reset: only bus writes alter them
    always_ff @(posedge clk) begin
        if (hi_wr)   hi_q <= wdata;
        if (lo_wr_o) lo_q <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            inh_q <= 1'b0;
        end else begin
            if (ctl_wr) ctl_q <= ctl_t'(wdata[CTL_W-1:0]);
            if (hi_wr)        inh_q <= 1'b1;
            else if (lo_wr_o) inh_q <= 1'b0;
        end
    end

    assign ctl_o     = ctl_q;
    assign cmp_o     = {hi_q, lo_q};
    assign inhibit_o = inh_q;

    // R4
    hi_inhibit_chk: assert property (@(posedge clk) disable iff (rst)
        hi_wr && !lo_wr_o |=> inh_q);

endmodule

// File: rtl/ocmp_match.sv
module ocmp_match
    import ocmp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CMP_W-1:0] cnt_value,
    input  logic             cnt_tick,
    input  logic [CMP_W-1:0] cmp,
    input  logic             inhibit,
    input  logic             lvl,
    input  logic             lo_wr,
    input  logic             sts_rd,
    output cmp_state_t       st_o
);
    cmp_state_t st_q;
    logic       arm_q;
    logic       hit;
    logic       clr;

    assign hit = cnt_tick && !inhibit && (cnt_value == cmp);
    assign clr = lo_wr && arm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '0;
            arm_q <= 1'b0;
        end else begin
            if (hit) begin
                st_q.hit_flag <= 1'b1;
                st_q.level    <= lvl;
                st_q.seen     <= 1'b1;
            end else if (clr) begin
                st_q.hit_flag <= 1'b0;
            end
            if (lo_wr)                        arm_q <= 1'b0;
            else if (sts_rd && st_q.hit_flag) arm_q <= 1'b1;
        end
    end

    assign st_o = st_q;

    // R6
    flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.hit_flag) |-> $past(cnt_tick) && ($past(cnt_value) == $past(cmp)));

    // R4
    inhibit_chk: assert property (@(posedge clk) disable iff (rst)
        inhibit |=> !$rose(st_q.hit_flag));

    // R10
    flag_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(st_q.hit_flag) |-> $past(lo_wr) && $past(arm_q));

    // R7
    level_move_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(st_q.level) |-> $past(cnt_tick));

endmodule

// File: rtl/ocmp_unit.sv
module ocmp_unit
    import ocmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [CMP_W-1:0]  cnt_value,
    input  logic              cnt_tick,
    output logic              irq,
    output logic              pin_val,
    output logic              pin_oe
);
    ctl_t             ctl;
    logic [CMP_W-1:0] cmp;
    logic             inhibit, lo_wr, sts_rd;
    cmp_state_t       st;

    ocmp_regfile u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .we       (bus_we),
        .re       (bus_re),
        .ctl_o    (ctl),
        .cmp_o    (cmp),
        .inhibit_o(inhibit),
        .lo_wr_o  (lo_wr),
        .sts_rd_o (sts_rd)
    );

    ocmp_match u_match (
        .clk      (clk),
        .rst      (rst),
        .cnt_value(cnt_value),
        .cnt_tick (cnt_tick),
        .cmp      (cmp),
        .inhibit  (inhibit),
        .lvl      (ctl.lvl),
        .lo_wr    (lo_wr),
        .sts_rd   (sts_rd),
        .st_o     (st)
    );

    always_comb begin
        bus_rdata = '0;
        if (addr_is(bus_addr, A_CTL))      bus_rdata = {{(BUS_W-CTL_W){1'b0}}, ctl};
        else if (addr_is(bus_addr, A_STS)) bus_rdata = {{(BUS_W-1){1'b0}}, st.hit_flag};
        else if (addr_is(bus_addr, A_HI))  bus_rdata = cmp[CMP_W-1:BUS_W];
        else if (addr_is(bus_addr, A_LO))  bus_rdata = cmp[BUS_W-1:0];
    end

    assign irq     = st.hit_flag && ctl.ien;
    assign pin_val = st.level;
    assign pin_oe  = st.seen && ctl.dir;

    // R9
    oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
        pin_oe |-> st.seen);

    // R8
    irq_src_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> st.hit_flag);

endmodule

// File: tb/sim_ocmp_unit.sv
module sim_ocmp_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0, bus_wdata = '0, bus_rdata;
    logic        bus_we = 1'b0, bus_re = 1'b0;
    logic [15:0] cnt_value = '0;
    logic        cnt_tick = 1'b0;
    logic        irq, pin_val, pin_oe;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    typedef enum int {K_RD, K_IRQ, K_PIN, K_OE} kind_e;
    typedef struct {
        kind_e      kind;
        logic [7:0] exp;
        string      req;
    } item_t;
    item_t q[$];

    always #4 clk = ~clk;

    ocmp_unit u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .cnt_value(cnt_value), .cnt_tick(cnt_tick),
        .irq(irq), .pin_val(pin_val), .pin_oe(pin_oe)
    );

    // one bus/counter cycle; returns just after the active edge
    task automatic cyc(input logic [7:0] a, input logic [7:0] d, input logic we,
                       input logic re, input logic tk, input logic [15:0] cv);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = we; bus_re = re;
        cnt_tick = tk; cnt_value = cv;
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        cyc(a, d, 1'b1, 1'b0, 1'b0, 16'h0);
    endtask

    task automatic tick(input logic [15:0] cv, input logic tk);
        cyc(8'h00, 8'h00, 1'b0, 1'b0, tk, cv);
    endtask

    task automatic expect_item(input kind_e k, input logic [7:0] e, input string r);
        item_t it;
        it.kind = k; it.exp = e; it.req = r;
        q.push_back(it);
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string r);
        cyc(a, 8'h00, 1'b0, 1'b1, 1'b0, 16'h0);
        expect_item(K_RD, e, r);
    endtask

    // monitor: pops expectations and compares with outputs
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (q.size() > 0) begin
                item_t it;
                logic [7:0] got;
                it = q.pop_front();
                case (it.kind)
                    K_RD:    got = bus_rdata;
                    K_IRQ:   got = {7'b0, irq};
                    K_PIN:   got = {7'b0, pin_val};
                    default: got = {7'b0, pin_oe};
                endcase
                tests++;
                if (got !== it.exp) begin
                    fails++;
                    $display("FAIL %s kind=%0d got=%h exp=%h", it.req, it.kind, got, it.exp);
                end
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !done) begin
                fails++;
                tests++;
                $display("FAIL watchdog got=%0d exp=<100000", cycles);
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        expect_item(K_IRQ, 8'h0, "R1 irq");
        expect_item(K_PIN, 8'h0, "R1 pin_val");
        expect_item(K_OE,  8'h0, "R1 pin_oe");
        @(negedge clk); rst = 1'b0;
        rd(8'h12, 8'h00, "R1 ctl");
        rd(8'h13, 8'h00, "R1 status");

        // R2 readback and byte independence
        wr(8'h16, 8'h12); wr(8'h17, 8'h34);
        rd(8'h16, 8'h12, "R2 hi");
        rd(8'h17, 8'h34, "R2 lo");
        wr(8'h17, 8'h56);
        rd(8'h16, 8'h12, "R2 hi kept");
        rd(8'h17, 8'h56, "R2 lo new");
        wr(8'h16, 8'h12); wr(8'h17, 8'h34);

        // R6 match gating; level=1, ien=1, dir=1
        wr(8'h12, 8'h07);
        tick(16'h1233, 1'b1); expect_item(K_IRQ, 8'h0, "R6 unequal");
        tick(16'h1234, 1'b0); expect_item(K_IRQ, 8'h0, "R6 no strobe");
        tick(16'h1234, 1'b1);
        expect_item(K_IRQ, 8'h1, "R6 match");
        expect_item(K_PIN, 8'h1, "R6 level");
        expect_item(K_OE,  8'h1, "R9 enabled");
        rd(8'h16, 8'h12, "R3 hi after match");
        rd(8'h17, 8'h34, "R3 lo after match");

        // R7 level moves on a second match with flag already set
        wr(8'h12, 8'h06);
        tick(16'h1234, 1'b1);
        expect_item(K_PIN, 8'h0, "R7 level on set flag");
        expect_item(K_IRQ, 8'h1, "R7 flag kept");

        // R10 clear handshake
        wr(8'h17, 8'h34); expect_item(K_IRQ, 8'h1, "R10 no prior read");
        rd(8'h13, 8'h01, "R10 status set");
        wr(8'h17, 8'h34); expect_item(K_IRQ, 8'h0, "R10 cleared");
        rd(8'h13, 8'h00, "R10 status clear");

        // R8 interrupt enable gating
        wr(8'h12, 8'h05);
        tick(16'h1234, 1'b1); expect_item(K_IRQ, 8'h0, "R8 disabled");
        wr(8'h12, 8'h07); expect_item(K_IRQ, 8'h1, "R8 enabled");
        rd(8'h13, 8'h01, "R8 status");
        wr(8'h17, 8'h34); expect_item(K_IRQ, 8'h0, "R10 clear again");

        // R4 high write inhibits until low write
        wr(8'h16, 8'h20);
        tick(16'h2034, 1'b1); expect_item(K_IRQ, 8'h0, "R4 inhibited");
        wr(8'h17, 8'h00);
        tick(16'h2000, 1'b1); expect_item(K_IRQ, 8'h1, "R4 resumed");
        rd(8'h13, 8'h01, "R4 status");
        wr(8'h17, 8'h10); expect_item(K_IRQ, 8'h0, "R5 clear");

        // R5 low-only write keeps matching
        tick(16'h2010, 1'b1); expect_item(K_IRQ, 8'h1, "R5 low only");

        // R11 match coincides with clearing write
        rd(8'h13, 8'h01, "R11 arm");
        cyc(8'h17, 8'h10, 1'b1, 1'b0, 1'b1, 16'h2010);
        expect_item(K_IRQ, 8'h1, "R11 flag kept");
        rd(8'h13, 8'h01, "R11 status");

        // R9 direction gate
        wr(8'h12, 8'h03); expect_item(K_OE, 8'h0, "R9 dir off");

        // R3 reset keeps compare; R9 needs a match after reset
        @(negedge clk); rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        rd(8'h16, 8'h20, "R3 hi after reset");
        rd(8'h17, 8'h10, "R3 lo after reset");
        expect_item(K_PIN, 8'h0, "R1 level reset");
        wr(8'h12, 8'h04); expect_item(K_OE, 8'h0, "R9 no match yet");
        tick(16'h2010, 1'b1); expect_item(K_OE, 8'h1, "R9 after match");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule